// File: doc/BRIEF.md
# Constant-Hue Chroma Gamut Limiter

This block sits in a video pipeline after filtering and scaling. It receives one YCbCr sample per handshake, with 8-bit components and chroma centred on 128. From the luma and the signed chroma offsets it derives an RGB triple internally, and it tests that triple against a programmable cube whose lower and upper bound apply to all three channels. The RGB values are never output.

A sample that already lies inside the cube is passed through unchanged. A sample outside the cube is not clipped channel by channel. Its luma is kept, and both chroma offsets are multiplied by one shared fraction k/256. This pulls the colour straight toward neutral grey, which keeps its hue. The fraction is chosen by a bit-serial search, one bit per clock, so that the result is the most saturated legal colour along that line. Input and output are valid/ready streams. The block holds one sample at a time and closes its input while it works.

Top module: `chroma_gamut_limiter`

## Requirements
- R1: The output luma always equals the luma of the accepted sample, whatever happens to the chroma.
- R2: If the luma lies in [lo, hi] and all three derived channels lie in the cube, out_cb and out_cr equal the input chroma. A sample accepted on rising edge t is valid on the output after edge t+1.
- R3: The derived channels use dCb = Cb-128 and dCr = Cr-128. R = Y + 359·dCr/256. G = Y - (88·dCb + 183·dCr)/256. B = Y + 454·dCb/256. Each channel is rounded by adding 128 to the numerator (Y scaled by 256) and then taking floor division by 256. A channel is legal when lo <= value <= hi, bounds inclusive. The bounds are captured together with the sample at acceptance. Every output whose luma is in range is legal.
- R4: For an illegal sample, both output offsets equal k·dCb/256 and k·dCr/256 with the same k. The magnitude is truncated toward 128 and the sign of each offset is kept. This keeps the hue.
- R5: k starts at 0. For bit 7 down to bit 0, one bit per clock, the bit is set if the offsets scaled by the trial value are legal. The corrected sample is valid after edge t+9.
- R6: in_ready is low from the cycle after acceptance until the result has entered the output register.
- R7: While out_valid is high and out_ready is low, the output data stay stable and out_valid stays high. A finished result waits until the output register is free.
- R8: If the luma is below lo or above hi, out_cb and out_cr are both 128. The luma is still passed unchanged, with the same latency as R2.
- R9: After synchronous active-high reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_y | input | 8 | Input luma |
| in_cb | input | 8 | Input blue-difference chroma, neutral at 128 |
| in_cr | input | 8 | Input red-difference chroma, neutral at 128 |
| cube_lo | input | 8 | Lower bound for every RGB channel |
| cube_hi | input | 8 | Upper bound for every RGB channel |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_y | output | 8 | Output luma |
| out_cb | output | 8 | Output blue-difference chroma |
| out_cr | output | 8 | Output red-difference chroma |

## Verification
Some properties are checked on every cycle: each result written to the output with in-range luma lies inside the captured cube, no chroma offset changes sign, the search position falls by one per clock, the input closes after acceptance, and a stalled output neither changes nor gets overwritten. Other properties only the directed scenarios can show. These are that the chosen k is exactly the one the MSB-first search gives, that the latencies are 1 and 9 cycles, that legal and out-of-range-luma samples give the right chroma values, and that a second sample queues correctly behind a stalled output.

// File: rtl/cgl_pkg.sv
package cgl_pkg;

  localparam int CGL_DW    = 8;
  localparam int CGL_KW    = 8;
  localparam int COEF_FRAC = 8;
  localparam int ACC_W     = CGL_DW + COEF_FRAC + 6;
  localparam int BIT_W     = $clog2(CGL_KW);

  // colour-difference weights scaled by 2^COEF_FRAC
  localparam int W_R_CR = 359;
  localparam int W_G_CB = 88;
  localparam int W_G_CR = 183;
  localparam int W_B_CB = 454;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_SRCH, ST_WAIT} cgl_state_e;

  typedef logic signed [CGL_DW:0]        off_t;
  typedef logic signed [ACC_W-1:0]       acc_t;
  typedef logic [CGL_DW+CGL_KW:0]        prod_t;
  typedef logic [CGL_DW-1:0]             comp_t;

  localparam off_t MID = off_t'(1 <<< (CGL_DW - 1));

  function automatic off_t to_off(input comp_t c);
    return $signed({1'b0, c}) - MID;
  endfunction

  function automatic comp_t from_off(input off_t d);
    off_t t;
    t = d + MID;
    return t[CGL_DW-1:0];
  endfunction

  // one derived channel, rounded to nearest
  function automatic acc_t mix_chan(input comp_t y, input off_t dcb, input off_t dcr,
                                    input int wcb, input int wcr);
    acc_t ys;
    acc_t acc;
    ys  = acc_t'($signed({1'b0, y}));
    acc = (ys <<< COEF_FRAC) + acc_t'(wcb) * acc_t'(dcb) + acc_t'(wcr) * acc_t'(dcr)
        + acc_t'(1 <<< (COEF_FRAC - 1));
    return acc >>> COEF_FRAC;
  endfunction

  function automatic logic in_cube(input acc_t v, input comp_t lo, input comp_t hi);
    acc_t l;
    acc_t h;
    l = acc_t'({1'b0, lo});
    h = acc_t'({1'b0, hi});
    return (v >= l) && (v <= h);
  endfunction

  function automatic logic rgb_ok(input comp_t y, input off_t dcb, input off_t dcr,
                                  input comp_t lo, input comp_t hi);
    return in_cube(mix_chan(y, dcb, dcr, 0, W_R_CR), lo, hi)
        && in_cube(mix_chan(y, dcb, dcr, -W_G_CB, -W_G_CR), lo, hi)
        && in_cube(mix_chan(y, dcb, dcr, W_B_CB, 0), lo, hi);
  endfunction

  // scale an offset by k/2^KW, magnitude truncated toward neutral
  function automatic off_t shrink(input logic [CGL_KW-1:0] k, input off_t d);
    logic [CGL_DW:0] mag;
    prod_t           prod;
    off_t            m;
    mag  = d[CGL_DW] ? $unsigned(-d) : $unsigned(d);
    prod = prod_t'(k) * prod_t'(mag);
    m    = off_t'(prod >> CGL_KW);
    return d[CGL_DW] ? -m : m;
  endfunction

endpackage

// File: rtl/cgl_rgb_legal.sv
module cgl_rgb_legal
  import cgl_pkg::*;
(
  input  comp_t y,
  input  off_t  dcb,
  input  off_t  dcr,
  input  comp_t lo,
  input  comp_t hi,
  output logic  legal
);
  localparam int NCH = 3;
  localparam int WCB [NCH] = '{0, -W_G_CB, W_B_CB};
  localparam int WCR [NCH] = '{W_R_CR, -W_G_CR, 0};

  logic [NCH-1:0] ch_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    acc_t v;
    assign v        = mix_chan(y, dcb, dcr, WCB[c], WCR[c]);
    assign ch_ok[c] = in_cube(v, lo, hi);
  end

  assign legal = &ch_ok;
endmodule

// File: rtl/cgl_shrink.sv
module cgl_shrink
  import cgl_pkg::*;
(
  input  logic [CGL_KW-1:0] k,
  input  off_t              dcb,
  input  off_t              dcr,
  output off_t              scb,
  output off_t              scr
);
  assign scb = shrink(k, dcb);
  assign scr = shrink(k, dcr);
endmodule

// File: rtl/cgl_out_stage.sv
module cgl_out_stage
  import cgl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  comp_t d_y,
  input  comp_t d_cb,
  input  comp_t d_cr,
  input  logic  out_ready,
  output logic  slot_free,
  output logic  out_valid,
  output comp_t out_y,
  output comp_t out_cb,
  output comp_t out_cr
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_cb    <= '0;
      out_cr    <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_y     <= d_y;
      out_cb    <= d_cb;
      out_cr    <= d_cr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: stalled output keeps its data
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_cb) && $stable(out_cr));

  // R7: a result is written only into a free slot
  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
    load |-> slot_free);
endmodule

// File: rtl/chroma_gamut_limiter.sv
module chroma_gamut_limiter
  import cgl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_y,
  input  logic [7:0] in_cb,
  input  logic [7:0] in_cr,
  input  logic [7:0] cube_lo,
  input  logic [7:0] cube_hi,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_y,
  output logic [7:0] out_cb,
  output logic [7:0] out_cr
);
  cgl_state_e        state;
  comp_t             cap_y, cap_lo, cap_hi;
  off_t              cap_dcb, cap_dcr;
  off_t              pend_cb, pend_cr;
  logic [CGL_KW-1:0] k_q;
  logic [BIT_W-1:0]  bit_q;

  // named internal events
  logic accept, luma_oor, src_ok, trial_ok, srch_start, res_valid, out_load, slot_free;
  logic [CGL_KW-1:0] trial_k, k_next;
  off_t trial_cb, trial_cr, fin_cb, fin_cr, res_cb, res_cr;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign luma_oor = (cap_y < cap_lo) || (cap_y > cap_hi);

  cgl_rgb_legal u_chk_src (
    .y(cap_y), .dcb(cap_dcb), .dcr(cap_dcr), .lo(cap_lo), .hi(cap_hi), .legal(src_ok));

  assign trial_k = k_q | (CGL_KW'(1) << bit_q);

  cgl_shrink u_scl_trial (.k(trial_k), .dcb(cap_dcb), .dcr(cap_dcr), .scb(trial_cb), .scr(trial_cr));

  cgl_rgb_legal u_chk_trial (
    .y(cap_y), .dcb(trial_cb), .dcr(trial_cr), .lo(cap_lo), .hi(cap_hi), .legal(trial_ok));

  assign k_next = trial_ok ? trial_k : k_q;

  cgl_shrink u_scl_final (.k(k_next), .dcb(cap_dcb), .dcr(cap_dcr), .scb(fin_cb), .scr(fin_cr));

  always_comb begin
    res_valid  = 1'b0;
    srch_start = 1'b0;
    res_cb     = cap_dcb;
    res_cr     = cap_dcr;
    unique case (state)
      ST_EVAL: begin
        if (luma_oor) begin
          res_valid = 1'b1;
          res_cb    = '0;
          res_cr    = '0;
        end else if (src_ok) begin
          res_valid = 1'b1;
        end else begin
          srch_start = 1'b1;
        end
      end
      ST_SRCH: begin
        if (bit_q == '0) begin
          res_valid = 1'b1;
          res_cb    = fin_cb;
          res_cr    = fin_cr;
        end
      end
      ST_WAIT: begin
        res_valid = 1'b1;
        res_cb    = pend_cb;
        res_cr    = pend_cr;
      end
      default: ;
    endcase
  end

  assign out_load = res_valid && slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cap_y   <= '0;
      cap_lo  <= '0;
      cap_hi  <= '1;
      cap_dcb <= '0;
      cap_dcr <= '0;
      pend_cb <= '0;
      pend_cr <= '0;
      k_q     <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cap_y   <= in_y;
            cap_dcb <= to_off(in_cb);
            cap_dcr <= to_off(in_cr);
            cap_lo  <= cube_lo;
            cap_hi  <= cube_hi;
            state   <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (srch_start) begin
            k_q   <= '0;
            bit_q <= BIT_W'(CGL_KW - 1);
            state <= ST_SRCH;
          end else if (out_load) begin
            state <= ST_IDLE;
          end else begin
            pend_cb <= res_cb;
            pend_cr <= res_cr;
            state   <= ST_WAIT;
          end
        end
        ST_SRCH: begin
          k_q   <= k_next;
          bit_q <= bit_q - 1'b1;
          if (res_valid) begin
            if (out_load) begin
              state <= ST_IDLE;
            end else begin
              pend_cb <= res_cb;
              pend_cr <= res_cr;
              state   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (out_load) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  cgl_out_stage u_out (
    .clk(clk), .rst(rst), .load(out_load),
    .d_y(cap_y), .d_cb(from_off(res_cb)), .d_cr(from_off(res_cr)),
    .out_ready(out_ready), .slot_free(slot_free),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr));

  // R6: input closes right after a sample is taken
  p_busy_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R3: every written result with in-range luma is inside the captured cube
  p_result_legal_r3: assert property (@(posedge clk) disable iff (rst)
    out_load && !luma_oor |-> rgb_ok(cap_y, res_cb, res_cr, cap_lo, cap_hi));

  // R4: no chroma offset changes side of neutral
  p_hue_kept_r4: assert property (@(posedge clk) disable iff (rst)
    out_load |-> ((res_cb == '0) || (res_cb[CGL_DW] == cap_dcb[CGL_DW]))
              && ((res_cr == '0) || (res_cr[CGL_DW] == cap_dcr[CGL_DW])));

  // R5: search walks one bit per clock
  p_search_step_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SRCH) && (bit_q != '0) |=> (state == ST_SRCH) && (bit_q == $past(bit_q) - 1'b1));
endmodule

// File: tb/chroma_gamut_limiter_bench.sv
module chroma_gamut_limiter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic [7:0] cube_lo = 8'd0, cube_hi = 8'd255;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_y, out_cb, out_cr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chroma_gamut_limiter u_chroma_gamut_limiter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .cube_lo(cube_lo), .cube_hi(cube_hi),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr));

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model, written as plain integer arithmetic
  function automatic int chan_b(int y, int dcb, int dcr, int ch);
    int num;
    if (ch == 0)      num = y * 256 + 359 * dcr;
    else if (ch == 1) num = y * 256 - 88 * dcb - 183 * dcr;
    else              num = y * 256 + 454 * dcb;
    num = num + 128;
    if (num >= 0) return num / 256;
    return -((-num + 255) / 256);
  endfunction

  function automatic bit inside_b(int y, int dcb, int dcr, int lo, int hi);
    for (int c = 0; c < 3; c++) begin
      int v;
      v = chan_b(y, dcb, dcr, c);
      if (v < lo || v > hi) return 0;
    end
    return 1;
  endfunction

  function automatic int shrink_b(int k, int d);
    if (d < 0) return -((k * (-d)) / 256);
    return (k * d) / 256;
  endfunction

  task automatic predict(int y, int cb, int cr, int lo, int hi,
                         output int ecb, output int ecr, output int elat);
    int dcb;
    int dcr;
    int k;
    dcb = cb - 128;
    dcr = cr - 128;
    k = 0;
    if (y < lo || y > hi) begin
      ecb = 128; ecr = 128; elat = 1;
    end else if (inside_b(y, dcb, dcr, lo, hi)) begin
      ecb = cb; ecr = cr; elat = 1;
    end else begin
      for (int b = 7; b >= 0; b--) begin
        int t;
        t = k | (1 << b);
        if (inside_b(y, shrink_b(t, dcb), shrink_b(t, dcr), lo, hi)) k = t;
      end
      ecb = 128 + shrink_b(k, dcb);
      ecr = 128 + shrink_b(k, dcr);
      elat = 9;
    end
  endtask

  // drive at a falling edge, return at the falling edge after acceptance
  task automatic send(int y, int cb, int cr);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_y  = 8'(y);
    in_cb = 8'(cb);
    in_cr = 8'(cr);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(string req, int y, int cb, int cr);
    int ecb, ecr, elat, lat;
    int lo, hi;
    lo = int'(cube_lo);
    hi = int'(cube_hi);
    predict(y, cb, cr, lo, hi, ecb, ecr, elat);
    send(y, cb, cr);
    check("R6", "in_ready after accept", int'(in_ready), 0);
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(elat == 1 ? "R2" : "R5", "latency", lat, elat);
    check("R1", "luma", int'(out_y), y);
    check(req, "cb", int'(out_cb), ecb);
    check(req, "cr", int'(out_cr), ecr);
    if (y >= lo && y <= hi)
      check("R3", "output inside cube",
            int'(inside_b(int'(out_y), int'(out_cb) - 128, int'(out_cr) - 128, lo, hi)), 1);
    if (elat == 9) begin
      check("R4", "cb side kept", int'((int'(out_cb) - 128) * (cb - 128) >= 0), 1);
      check("R4", "cr side kept", int'((int'(out_cr) - 128) * (cr - 128) >= 0), 1);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R9", "out_valid after reset", int'(out_valid), 0);
    check("R9", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_pass;
    cube_lo = 8'd0; cube_hi = 8'd255;
    run_one("R2", 128, 128, 128);
    run_one("R2", 100, 140, 120);
    run_one("R2", 200, 128, 128);
  endtask

  task automatic t_search;
    cube_lo = 8'd0; cube_hi = 8'd255;
    run_one("R4", 235, 240, 240);
    run_one("R4", 16, 16, 240);
    run_one("R5", 0, 0, 0);
    run_one("R5", 255, 255, 255);
    run_one("R4", 128, 0, 255);
  endtask

  task automatic t_narrow;
    cube_lo = 8'd16; cube_hi = 8'd235;
    run_one("R3", 40, 110, 128);
    run_one("R3", 220, 160, 150);
    run_one("R3", 128, 140, 120);
  endtask

  task automatic t_luma_oor;
    cube_lo = 8'd16; cube_hi = 8'd235;
    run_one("R8", 10, 200, 60);
    run_one("R8", 250, 90, 170);
    cube_lo = 8'd0; cube_hi = 8'd255;
  endtask

  task automatic t_backpressure;
    int ay, acb, acr, ecb, ecr, elat;
    cube_lo = 8'd0; cube_hi = 8'd255;
    out_ready = 1'b0;
    send(235, 240, 240);
    while (!out_valid) @(negedge clk);
    ay = int'(out_y); acb = int'(out_cb); acr = int'(out_cr);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7", "valid held", int'(out_valid), 1);
      check("R7", "cb held", int'(out_cb), acb);
      check("R7", "cr held", int'(out_cr), acr);
      check("R7", "y held", int'(out_y), ay);
    end
    check("R6", "idle while output full", int'(in_ready), 1);
    predict(100, 140, 120, 0, 255, ecb, ecr, elat);
    send(100, 140, 120);
    @(negedge clk);
    check("R6", "in_ready low while result waits", int'(in_ready), 0);
    check("R7", "first result still shown", int'(out_cb), acb);
    out_ready = 1'b1;
    @(negedge clk);
    check("R7", "queued valid", int'(out_valid), 1);
    check("R7", "queued y", int'(out_y), 100);
    check("R7", "queued cb", int'(out_cb), ecb);
    check("R7", "queued cr", int'(out_cr), ecr);
    @(negedge clk);
    check("R7", "drained", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_pass;
    t_search;
    t_narrow;
    t_luma_oor;
    t_backpressure;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule